// File: doc/BRIEF.md
# Serial Display Command Receiver

This block is the control front end of a segment display driver with a four-phase common scan. It takes 8-bit words from a slow serial link that has a clock, a data line, a low-active chip select and a mode line. The block samples all four link lines in its own system clock domain. Each completed word is either display data or a command, as chosen by the mode line at the eighth serial clock edge.

Commands load a 5-bit RAM address, pick one of three display modes, rewrite one 4-bit cell, or return the block to its idle state. A display-data word fills two neighbouring cells, high nibble first. A 32 x 4 register file holds the picture. The segment drive logic reads it through a combinational read port and uses the display mode output to decide whether to blank, light everything or show the RAM.

Top module: `disp_cmd_rx`

## Requirements
- R1: While `rst_n` is low, `disp_mode` is 2'b00 (blank), the address counter is cleared to 0 and every RAM cell reads 0.
- R2: A word is 8 bits, shifted in MSB first, one bit per rising edge of `ser_clk` seen while `ser_cs_n` is low. Rising edges seen while `ser_cs_n` is high change nothing.
- R3: A high-to-low transition of `ser_cs_n` clears the bit count, so bits of an unfinished word are dropped.
- R4: `ser_mode` is sampled with the eighth bit. Low makes the word display data and high makes it a command.
- R5: A display-data word writes bits [7:4] to the current address and bits [3:0] to the current address + 1, both MSB aligned. The address then advances by 2.
- R6: Command code 3'b000 in bits [7:5] loads bits [4:0] into the address counter.
- R7: Command codes 3'b001, 3'b010 and 3'b011 set `disp_mode` to 2'b01 (all on), 2'b00 (blank) and 2'b10 (show RAM). Their bits [4:0] are ignored and they leave the RAM unchanged.
- R8: Command code 3'b100 writes bits [3:0] to the current address and then advances the address by 1. Bit 4 is ignored.
- R9: Command code 3'b110 sets `disp_mode` to blank and clears the address counter. The RAM is kept.
- R10: Command codes 3'b101 and 3'b111 change no state.
- R11: The address counter is modulo 32. A data word that starts at 0x1F puts its second nibble at 0x00 and leaves the address at 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, low active |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_cs_n | input | 1 | Chip select, low active |
| ser_mode | input | 1 | Word kind: 0 data, 1 command |
| rd_addr | input | 5 | RAM read address from the drive logic |
| rd_nib | output | 4 | RAM cell at `rd_addr` |
| disp_mode | output | 2 | 00 blank, 01 all on, 10 show RAM |

## Verification
A wrong bit count or a wrong mode sample puts a wrong nibble into the RAM or the wrong value on `disp_mode`. The error shows within about ten system clocks after the word ends. A wrong address counter cannot be seen until the next write, so every address fault is exposed through the cell that the following word or rewrite lands in. The bench keeps the read address sweeping so that every cell is compared between words.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [1:0] {
        DM_BLANK  = 2'b00,
        DM_ALL_ON = 2'b01,
        DM_RAM    = 2'b10
    } disp_mode_e;

    typedef enum logic [2:0] {
        OP_ADDR    = 3'b000,
        OP_ALL_ON  = 3'b001,
        OP_BLANK   = 3'b010,
        OP_SHOW    = 3'b011,
        OP_REWRITE = 3'b100,
        OP_NOP5    = 3'b101,
        OP_RESET   = 3'b110,
        OP_NOP7    = 3'b111
    } op_e;

endpackage

// File: rtl/dcr_sync.sv
module dcr_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/dcr_serial_rx.sv
module dcr_serial_rx #(
    parameter int WORD_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_cs_n,
    input  logic              ser_mode,
    output logic              word_vld,
    output logic [WORD_W-1:0] word,
    output logic              word_cmd
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shf;
        logic              vld;
        logic              cmd;
        logic              sck_prev;
        logic              cs_prev;
    } rx_t;

    rx_t r_d, r_q;

    logic [3:0] s_vec;
    logic s_sck, s_dat, s_csn, s_mode;
    logic sck_rise, cs_fall;

    dcr_sync #(.W(4), .STAGES(SYNC_N), .RST_VAL(4'b0010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_dat, ser_cs_n, ser_mode}),
        .q     (s_vec)
    );

    assign {s_sck, s_dat, s_csn, s_mode} = s_vec;
    assign sck_rise = s_sck & ~r_q.sck_prev;
    assign cs_fall  = r_q.cs_prev & ~s_csn;

    always_comb begin
        r_d          = r_q;
        r_d.vld      = 1'b0;
        r_d.sck_prev = s_sck;
        r_d.cs_prev  = s_csn;
        if (!s_csn) begin
            if (cs_fall) begin
                r_d.cnt = '0;
            end else if (sck_rise) begin
                r_d.shf = {r_q.shf[WORD_W-2:0], s_dat};
                if (r_q.cnt == CNT_W'(WORD_W-1)) begin
                    r_d.cnt = '0;
                    r_d.vld = 1'b1;
                    r_d.cmd = s_mode;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.sck_prev <= 1'b0;
            r_q.cs_prev  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_vld = r_q.vld;
    assign word     = r_q.shf;
    assign word_cmd = r_q.cmd;

    // R2: a word can only finish on a clock edge seen with select low
    assert_word_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.vld |-> $past(!s_csn && sck_rise));

    // R3: a select fall leaves the count at zero
    assert_fall_clears_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (r_q.cnt == '0) && !r_q.vld);
endmodule

// File: rtl/dcr_seq.sv
module dcr_seq
    import dcr_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 5,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic              word_cmd,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [NIB_W-1:0]  wr_data,
    output logic [1:0]        disp_mode
);
    localparam int OP_LSB = WORD_W - 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        disp_mode_e        mode;
        logic              pend;
        logic [NIB_W-1:0]  pend_nib;
    } seq_t;

    seq_t s_d, s_q;
    op_e  op;

    assign op = op_e'(word[WORD_W-1:OP_LSB]);

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_addr = s_q.addr;
        wr_data = '0;
        if (s_q.pend) begin
            wr_en      = 1'b1;
            wr_data    = s_q.pend_nib;
            s_d.addr   = s_q.addr + ADDR_W'(1);
            s_d.pend   = 1'b0;
        end else if (word_vld) begin
            if (!word_cmd) begin
                wr_en        = 1'b1;
                wr_data      = word[WORD_W-1 -: NIB_W];
                s_d.pend     = 1'b1;
                s_d.pend_nib = word[NIB_W-1:0];
                s_d.addr     = s_q.addr + ADDR_W'(1);
            end else begin
                unique case (op)
                    OP_ADDR:    s_d.addr = word[ADDR_W-1:0];
                    OP_ALL_ON:  s_d.mode = DM_ALL_ON;
                    OP_BLANK:   s_d.mode = DM_BLANK;
                    OP_SHOW:    s_d.mode = DM_RAM;
                    OP_REWRITE: begin
                        wr_en    = 1'b1;
                        wr_data  = word[NIB_W-1:0];
                        s_d.addr = s_q.addr + ADDR_W'(1);
                    end
                    OP_RESET: begin
                        s_d.mode = DM_BLANK;
                        s_d.addr = '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= DM_BLANK;
        end else begin
            s_q <= s_d;
        end
    end

    assign disp_mode = s_q.mode;

    // R5 / R11: a data word moves the address by two, modulo the depth
    assert_data_step_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && !word_cmd) |-> ##2 (s_q.addr == $past(s_q.addr, 2) + ADDR_W'(2)));

    // R7: mode commands never write the RAM
    assert_mode_cmd_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_cmd && (op == OP_ALL_ON || op == OP_BLANK || op == OP_SHOW))
        |-> !wr_en);

    // R9: reset command ends blank at address zero
    assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_cmd && op == OP_RESET) |=> (s_q.addr == '0) && (s_q.mode == DM_BLANK));

    // R10: undefined codes keep address and mode
    assert_nop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_cmd && (op == OP_NOP5 || op == OP_NOP7) && !s_q.pend)
        |=> $stable(s_q.addr) && $stable(s_q.mode));

    // R7: mode register only holds defined encodings
    assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mode != 2'b11);
endmodule

// File: rtl/dcr_nib_ram.sv
module dcr_nib_ram #(
    parameter int ADDR_W = 5,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NIB_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [NIB_W-1:0] mem_q [DEPTH];
    logic [NIB_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R8: a write is visible at its address on the next cycle
    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 5,
    parameter int NIB_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_cs_n,
    input  logic              ser_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NIB_W-1:0]  rd_nib,
    output logic [1:0]        disp_mode
);
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              word_cmd;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [NIB_W-1:0]  wr_data;

    dcr_serial_rx #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_dat  (ser_dat),
        .ser_cs_n (ser_cs_n),
        .ser_mode (ser_mode),
        .word_vld (word_vld),
        .word     (word),
        .word_cmd (word_cmd)
    );

    dcr_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_vld  (word_vld),
        .word      (word),
        .word_cmd  (word_cmd),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .disp_mode (disp_mode)
    );

    dcr_nib_ram #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_nib)
    );
endmodule

// File: tb/disp_cmd_rx_test.sv
module disp_cmd_rx_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_cs_n = 1'b1;
    logic       ser_mode = 1'b0;
    logic [4:0] rd_addr = '0;
    logic [3:0] rd_nib;
    logic [1:0] disp_mode;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    settled = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int m_mem [32];
    int m_addr;
    int m_mode;

    disp_cmd_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_cs_n  (ser_cs_n),
        .ser_mode  (ser_mode),
        .rd_addr   (rd_addr),
        .rd_nib    (rd_nib),
        .disp_mode (disp_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles  <= cycles + 1;
        rd_addr <= rd_addr + 5'd1;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (settled && rst_n) begin
            chk({cur_req, " disp_mode"}, int'(disp_mode), m_mode);
            chk({cur_req, " rd_nib"}, int'(rd_nib), m_mem[rd_addr]);
        end
    end

    function automatic void model_reset();
        for (int i = 0; i < 32; i++) m_mem[i] = 0;
        m_addr = 0;
        m_mode = 0;
    endfunction

    function automatic void model_word(input int b, input bit cmd);
        if (!cmd) begin
            m_mem[m_addr] = (b >> 4) & 15;
            m_mem[(m_addr + 1) % 32] = b & 15;
            m_addr = (m_addr + 2) % 32;
        end else begin
            case ((b >> 5) & 7)
                0: m_addr = b & 31;
                1: m_mode = 1;
                2: m_mode = 0;
                3: m_mode = 2;
                4: begin
                    m_mem[m_addr] = b & 15;
                    m_addr = (m_addr + 1) % 32;
                end
                6: begin
                    m_mode = 0;
                    m_addr = 0;
                end
                default: ;
            endcase
        end
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        ser_dat = b;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        ser_clk = 1'b0;
    endtask

    task automatic select(input bit low);
        ser_cs_n = !low;
        wait_n(6);
    endtask

    task automatic send_word(input string req, input int b, input bit cmd);
        settled  = 1'b0;
        cur_req  = req;
        ser_mode = cmd;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wait_n(8);
        model_word(b, cmd);
        settled = 1'b1;
        wait_n(40);
    endtask

    task automatic pin_reset();
        settled  = 1'b0;
        ser_cs_n = 1'b1;
        ser_clk  = 1'b0;
        wait_n(2);
        rst_n = 1'b0;
        model_reset();
        wait_n(3);
        cur_req = "R1";
        settled = 1'b1;
        wait_n(2);
        rst_n = 1'b1;
        wait_n(40);
    endtask

    initial begin
        model_reset();
        wait_n(3);
        cur_req = "R1";
        settled = 1'b1;
        chk("R1 mode in reset", int'(disp_mode), 0);
        wait_n(2);
        rst_n = 1'b1;
        wait_n(40);

        select(1'b1);
        // R7: mode commands with junk in the low bits
        send_word("R7 show", 8'h7F, 1'b1);
        send_word("R7 all_on", 8'h35, 1'b1);
        send_word("R7 blank", 8'h5A, 1'b1);
        send_word("R7 show", 8'h60, 1'b1);
        // R6 / R5: address load then data words
        send_word("R6 addr", 8'h05, 1'b1);
        send_word("R5 data", 8'hA5, 1'b0);
        send_word("R5 data", 8'h3C, 1'b0);
        // R8: rewrite with bit 4 set, lands at 9
        send_word("R8 rewrite", 8'h9E, 1'b1);
        send_word("R8 rewrite", 8'h81, 1'b1);
        // R11: wrap of the second nibble
        send_word("R6 addr", 8'h1F, 1'b1);
        send_word("R11 data wrap", 8'h71, 1'b0);
        send_word("R11 after wrap", 8'h8D, 1'b1);
        send_word("R6 addr", 8'h1F, 1'b1);
        send_word("R11 rewrite wrap", 8'h82, 1'b1);
        send_word("R11 after wrap", 8'h84, 1'b1);
        // R10: undefined codes
        send_word("R10 nop5", 8'hA7, 1'b1);
        send_word("R10 nop7", 8'hFF, 1'b1);
        send_word("R10 after nop", 8'h8B, 1'b1);
        // R9: reset command keeps RAM
        send_word("R6 addr", 8'h10, 1'b1);
        send_word("R9 reset cmd", 8'hC3, 1'b1);
        send_word("R9 after reset", 8'h96, 1'b0);
        send_word("R7 show", 8'h60, 1'b1);

        // R2: edges while select is high do nothing
        select(1'b0);
        settled = 1'b1;
        cur_req = "R2 deselected";
        ser_mode = 1'b0;
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        wait_n(40);
        select(1'b1);
        send_word("R2 after deselect", 8'h42, 1'b0);

        // R3: partial word dropped by select fall
        cur_req = "R3 partial";
        ser_mode = 1'b1;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        select(1'b0);
        select(1'b1);
        send_word("R3 after partial", 8'h19, 1'b0);
        send_word("R4 mode high", 8'h83, 1'b1);
        send_word("R4 mode low", 8'h83, 1'b0);

        // R5 / R11: fill whole RAM with computed pattern
        send_word("R6 addr", 8'h03, 1'b1);
        for (int k = 0; k < 16; k++) begin
            send_word("R5 fill", (k * 37 + 11) & 255, 1'b0);
        end

        // R1: reset pin mid-run clears RAM, mode, address
        pin_reset();
        select(1'b1);
        send_word("R1 after pin reset", 8'hE7, 1'b0);
        send_word("R7 all_on", 8'h20, 1'b1);
        settled = 1'b0;
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000 || done);
        if (!done) begin
            fails++;
            $display("FAIL watchdog %s actual=%0d expected=done", cur_req, cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule